// File: doc/BRIEF.md
# Prioritized Interrupt Request Arbiter

The block collects a parameterised set of interrupt request lines and decides which one the CPU serves next. Every source has an enable, a 4-bit priority level and a 3-bit group sub-level. Among the pending sources that are allowed to interrupt, the one with the highest combined level/group key wins. The block then presents that source's vector number, level and group to the CPU as a registered result.

Hardware trap inputs, including a non-maskable input, and a software trap command ride on the same output. They take precedence over all normal requests and ignore both the global enable and the CPU priority. The CPU takes a request by pulsing an acknowledge input. On that edge the served flag is cleared and the next winner is presented. One cycle later a save-context pulse tells the core to push its instruction pointer, status word and code segment pointer.

The number of sources is a parameter and is meant to be a multiple of 16, at most 112. Stack handling, the vector fetch and the pipeline lie outside the block. The acknowledge handshake stands in for all of them.

Top module: `irq_arbiter`

## Requirements
- R1: A one-cycle pulse on `irq_req_i[i]` sets the pending flag `pend_o[i]` at that clock edge. The flag stays set until source i is acknowledged.
- R2: A pending source is eligible only while `irq_en_i[i]` and `glob_en_i` are both 1 and its level is strictly greater than `cpu_prio_i`. Because of this, level 0 never interrupts.
- R3: Among eligible sources, the one with the largest key {level, group} wins. The output then shows `kind_o`=1 (normal request), `vec_o`=source index, `prio_o`=level and `grp_o`=group. A winner is always a source whose `pend_o` bit is set.
- R4: When two eligible sources have equal level and group, the lower source index wins.
- R5: All results are registered. A change of requests, enables, levels or `cpu_prio_i` shows on the outputs after the next rising clock edge and not before it. `req_o` is 1 exactly when `kind_o` is not 0.
- R6: An acknowledge (`ack_i`=1 while `req_o`=1) clears the served source's flag on that edge, and the outputs then show the next winner. An acknowledge while `req_o`=0 changes nothing.
- R7: Hardware traps are latched and outrank everything, with `kind_o`=3, `prio_o`=15 and `grp_o`=7. `vec_o` is 0 for `nmi_i` and k+1 for `trap_i[k]`. A lower vector wins, and neither `glob_en_i` nor `cpu_prio_i` gates a trap.
- R8: A `sw_valid_i` pulse latches a software trap with vector `sw_vec_i`. It shows as `kind_o`=2, `prio_o`=15, `grp_o`=7, below hardware traps and above normal requests, and it is not gated. A new command that arrives while one is still pending is dropped.
- R9: `save_ctx_o` is 1 for exactly the cycle after an acknowledged edge and 0 otherwise.
- R10: After reset, no flag is pending, `req_o`=0, `kind_o`=0 and `save_ctx_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | NUM_SRC | Request pulses, one per source |
| irq_en_i | input | NUM_SRC | Per-source enable |
| irq_lvl_i | input | NUM_SRC*4 | Priority level per source, source i in bits [4i+3:4i] |
| irq_grp_i | input | NUM_SRC*3 | Group sub-level per source, source i in bits [3i+2:3i] |
| glob_en_i | input | 1 | Global enable for normal requests |
| cpu_prio_i | input | 4 | Current CPU priority |
| nmi_i | input | 1 | Non-maskable trap pulse |
| trap_i | input | NUM_TRAP | Hardware trap pulses |
| sw_valid_i | input | 1 | Software trap command strobe |
| sw_vec_i | input | 7 | Software trap vector |
| ack_i | input | 1 | CPU acknowledge |
| req_o | output | 1 | A request is presented |
| kind_o | output | 2 | 0 none, 1 normal, 2 software trap, 3 hardware trap |
| vec_o | output | 7 | Vector number |
| prio_o | output | 4 | Level of the presented request |
| grp_o | output | 3 | Group of the presented request |
| save_ctx_o | output | 1 | Save-context pulse |
| pend_o | output | NUM_SRC | Pending flags |

## Verification
A request pulse, trap pulse or configuration change driven before a rising edge shows on the outputs right after that edge. An acknowledge moves the outputs to the next winner on its own edge, and `save_ctx_o` is high for the cycle that follows. The bench drives every input just after a falling edge and samples just after the next falling edge, so each check sees exactly one rising edge. One check samples straight after a `cpu_prio_i` change and before any edge, to show that the output has not moved yet. Expected winners come from an arithmetic model of the pending set, level, group and index kept in the bench.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int VEC_W = 7;
  localparam int LVL_W = 4;
  localparam int GRP_W = 3;
  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_IRQ  = 2'd1,
    K_SW   = 2'd2,
    K_HW   = 2'd3
  } kind_e;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_SRC-1:0]       req_i,
  input  logic [NUM_SRC-1:0]       clr_i,
  input  logic [NUM_SRC-1:0]       en_i,
  input  logic [NUM_SRC*LVL_W-1:0] lvl_i,
  input  logic                     glob_en_i,
  input  logic [LVL_W-1:0]         cpu_prio_i,
  output logic [NUM_SRC-1:0]       pend_o,
  output logic [NUM_SRC-1:0]       elig_o
);
  logic [NUM_SRC-1:0] pend_q, pend_d;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    // new pulse wins over a same-cycle clear
    assign pend_d[i] = (pend_q[i] & ~clr_i[i]) | req_i[i];
    assign elig_o[i] = pend_d[i] & en_i[i] & glob_en_i &
                       (lvl_i[i*LVL_W +: LVL_W] > cpu_prio_i);

    a_r1_pulse_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_i[i] |=> pend_q[i]);
    a_r6_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !req_i[i]) |=> !pend_q[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic [NUM_SRC-1:0]       elig_i,
  input  logic [NUM_SRC*LVL_W-1:0] lvl_i,
  input  logic [NUM_SRC*GRP_W-1:0] grp_i,
  output logic                     found_o,
  output logic [VEC_W-1:0]         idx_o,
  output logic [LVL_W-1:0]         lvl_o,
  output logic [GRP_W-1:0]         grp_o
);
  // strict compare keeps the lowest index on equal keys
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    lvl_o   = '0;
    grp_o   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig_i[i] && (!found_o ||
          {lvl_i[i*LVL_W +: LVL_W], grp_i[i*GRP_W +: GRP_W]} > {lvl_o, grp_o})) begin
        found_o = 1'b1;
        idx_o   = VEC_W'(i);
        lvl_o   = lvl_i[i*LVL_W +: LVL_W];
        grp_o   = grp_i[i*GRP_W +: GRP_W];
      end
    end
  end
endmodule

// File: rtl/irq_trap_ctl.sv
module irq_trap_ctl
  import irq_arb_pkg::*;
#(
  parameter int NUM_TRAP = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                nmi_i,
  input  logic [NUM_TRAP-1:0] trap_i,
  input  logic                sw_valid_i,
  input  logic [VEC_W-1:0]    sw_vec_i,
  input  logic [NUM_TRAP:0]   clr_hw_i,
  input  logic                clr_sw_i,
  output logic                hw_any_o,
  output logic [VEC_W-1:0]    hw_idx_o,
  output logic                sw_pend_o,
  output logic [VEC_W-1:0]    sw_vec_o
);
  localparam int NUM_HW = NUM_TRAP + 1;

  logic [NUM_HW-1:0] hw_q, hw_d;
  logic              sw_q, sw_d, sw_busy;
  logic [VEC_W-1:0]  swv_q, swv_d;

  assign hw_d    = (hw_q & ~clr_hw_i) | {trap_i, nmi_i};
  assign sw_busy = sw_q & ~clr_sw_i;
  assign sw_d    = sw_busy | sw_valid_i;
  assign swv_d   = (sw_valid_i && !sw_busy) ? sw_vec_i : swv_q;

  always_comb begin
    hw_idx_o = '0;
    for (int k = NUM_HW - 1; k >= 0; k--)
      if (hw_d[k]) hw_idx_o = VEC_W'(k);
  end

  assign hw_any_o  = |hw_d;
  assign sw_pend_o = sw_d;
  assign sw_vec_o  = swv_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hw_q  <= '0;
      sw_q  <= 1'b0;
      swv_q <= '0;
    end else begin
      hw_q  <= hw_d;
      sw_q  <= sw_d;
      swv_q <= swv_d;
    end
  end

  a_r8_sw_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_q && !clr_sw_i) |=> (sw_q && $stable(swv_q)));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC  = 16,
  parameter int NUM_TRAP = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_SRC-1:0]       irq_req_i,
  input  logic [NUM_SRC-1:0]       irq_en_i,
  input  logic [NUM_SRC*4-1:0]     irq_lvl_i,
  input  logic [NUM_SRC*3-1:0]     irq_grp_i,
  input  logic                     glob_en_i,
  input  logic [3:0]               cpu_prio_i,
  input  logic                     nmi_i,
  input  logic [NUM_TRAP-1:0]      trap_i,
  input  logic                     sw_valid_i,
  input  logic [6:0]               sw_vec_i,
  input  logic                     ack_i,
  output logic                     req_o,
  output logic [1:0]               kind_o,
  output logic [6:0]               vec_o,
  output logic [3:0]               prio_o,
  output logic [2:0]               grp_o,
  output logic                     save_ctx_o,
  output logic [NUM_SRC-1:0]       pend_o
);
  localparam int NUM_HW = NUM_TRAP + 1;

  kind_e              kind_q, kind_d;
  logic [VEC_W-1:0]   vec_q, vec_d;
  logic [LVL_W-1:0]   prio_q, prio_d;
  logic [GRP_W-1:0]   grp_q, grp_d;
  logic               save_q, ack_fire;
  logic [NUM_SRC-1:0] clr_irq, elig;
  logic [NUM_HW-1:0]  clr_hw;
  logic               clr_sw, found, hw_any, sw_pend;
  logic [VEC_W-1:0]   pick_idx, hw_idx, sw_vec;
  logic [LVL_W-1:0]   pick_lvl;
  logic [GRP_W-1:0]   pick_grp;

  assign ack_fire = ack_i & (kind_q != K_NONE);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_clr_irq
    assign clr_irq[g] = ack_fire && (kind_q == K_IRQ) && (vec_q == VEC_W'(g));
  end
  for (genvar g = 0; g < NUM_HW; g++) begin : g_clr_hw
    assign clr_hw[g] = ack_fire && (kind_q == K_HW) && (vec_q == VEC_W'(g));
  end
  assign clr_sw = ack_fire && (kind_q == K_SW);

  irq_src_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk_i, .rst_ni,
    .req_i(irq_req_i), .clr_i(clr_irq), .en_i(irq_en_i), .lvl_i(irq_lvl_i),
    .glob_en_i, .cpu_prio_i, .pend_o, .elig_o(elig)
  );

  irq_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .elig_i(elig), .lvl_i(irq_lvl_i), .grp_i(irq_grp_i),
    .found_o(found), .idx_o(pick_idx), .lvl_o(pick_lvl), .grp_o(pick_grp)
  );

  irq_trap_ctl #(.NUM_TRAP(NUM_TRAP)) u_trap (
    .clk_i, .rst_ni, .nmi_i, .trap_i, .sw_valid_i, .sw_vec_i,
    .clr_hw_i(clr_hw), .clr_sw_i(clr_sw),
    .hw_any_o(hw_any), .hw_idx_o(hw_idx), .sw_pend_o(sw_pend), .sw_vec_o(sw_vec)
  );

  always_comb begin
    kind_d = K_NONE;
    vec_d  = '0;
    prio_d = '0;
    grp_d  = '0;
    if (hw_any) begin
      kind_d = K_HW;  vec_d = hw_idx;  prio_d = '1;  grp_d = '1;
    end else if (sw_pend) begin
      kind_d = K_SW;  vec_d = sw_vec;  prio_d = '1;  grp_d = '1;
    end else if (found) begin
      kind_d = K_IRQ; vec_d = pick_idx; prio_d = pick_lvl; grp_d = pick_grp;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= K_NONE;
      vec_q  <= '0;
      prio_q <= '0;
      grp_q  <= '0;
      save_q <= 1'b0;
    end else begin
      kind_q <= kind_d;
      vec_q  <= vec_d;
      prio_q <= prio_d;
      grp_q  <= grp_d;
      save_q <= ack_fire;
    end
  end

  assign req_o      = (kind_q != K_NONE);
  assign kind_o     = kind_q;
  assign vec_o      = vec_q;
  assign prio_o     = prio_q;
  assign grp_o      = grp_q;
  assign save_ctx_o = save_q;

  a_r2_above_cpu: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_q == K_IRQ) |-> (prio_q > $past(cpu_prio_i)));
  a_r3_winner_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_q == K_IRQ) |-> (|(pend_o & (NUM_SRC'(1) << vec_q))));
  a_r7_hw_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_any |=> (kind_o == 2'd3));
  a_r8_sw_over_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_pend && !hw_any) |=> (kind_o == 2'd2));
  a_r9_save_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && req_o) |=> save_ctx_o);
  a_r9_save_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_i && req_o) |=> !save_ctx_o);
endmodule

// File: tb/sim_irq_arbiter.sv
module sim_irq_arbiter;
  localparam int N = 16;
  localparam int T = 2;

  logic clk_i = 1'b0;
  always #5 clk_i = ~clk_i;

  logic         rst_ni;
  logic [N-1:0] irq_req_i;
  logic [N*4-1:0] irq_lvl_i;
  logic [N*3-1:0] irq_grp_i;
  logic [T-1:0] trap_i;
  logic         nmi_i, sw_valid_i, ack_i;
  logic [6:0]   sw_vec_i;
  logic         req_o, save_ctx_o;
  logic [1:0]   kind_o;
  logic [6:0]   vec_o;
  logic [3:0]   prio_o;
  logic [2:0]   grp_o;
  logic [N-1:0] pend_o;

  logic [N-1:0] m_pend, m_en;
  logic [3:0]   m_lvl [N];
  logic [2:0]   m_grp [N];
  logic         m_glob;
  logic [3:0]   m_cpu;
  logic [31:0]  seed;
  int n_tests = 0;
  int n_fail  = 0;

  for (genvar g = 0; g < N; g++) begin : g_drv
    assign irq_lvl_i[g*4 +: 4] = m_lvl[g];
    assign irq_grp_i[g*3 +: 3] = m_grp[g];
  end

  irq_arbiter #(.NUM_SRC(N), .NUM_TRAP(T)) u0 (
    .clk_i, .rst_ni, .irq_req_i, .irq_en_i(m_en), .irq_lvl_i, .irq_grp_i,
    .glob_en_i(m_glob), .cpu_prio_i(m_cpu), .nmi_i, .trap_i, .sw_valid_i,
    .sw_vec_i, .ack_i, .req_o, .kind_o, .vec_o, .prio_o, .grp_o,
    .save_ctx_o, .pend_o
  );

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  function automatic int m_win();
    int w = -1;
    for (int i = 0; i < N; i++)
      if (m_pend[i] && m_en[i] && m_glob && (m_lvl[i] > m_cpu))
        if (w < 0 || {m_lvl[i], m_grp[i]} > {m_lvl[w], m_grp[w]}) w = i;
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic out_chk(input string tag, input logic [1:0] k, input int v,
                         input logic [3:0] p, input logic [2:0] gr);
    chk(tag, 32'({req_o, kind_o, vec_o, prio_o, grp_o}),
        32'({k != 2'd0, k, 7'(v), p, gr}));
  endtask

  task automatic chk_irq(input string tag);
    int w = m_win();
    if (w < 0) out_chk(tag, 2'd0, 0, 4'd0, 3'd0);
    else       out_chk(tag, 2'd1, w, m_lvl[w], m_grp[w]);
  endtask

  task automatic cyc();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic pulse_irq(input logic [N-1:0] mask);
    irq_req_i = mask;
    cyc();
    irq_req_i = '0;
    m_pend |= mask;
  endtask

  task automatic ack_irq(input string tag);
    int w = m_win();
    ack_i = 1'b1;
    cyc();
    ack_i = 1'b0;
    if (w >= 0) m_pend[w] = 1'b0;
    chk({tag, " R9 save"}, 32'(save_ctx_o), 32'(w >= 0));
    chk({tag, " R6 pend"}, 32'(pend_o), 32'(m_pend));
    chk_irq({tag, " R6 next"});
  endtask

  task automatic ack_raw();
    ack_i = 1'b1;
    cyc();
    ack_i = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    seed = 32'h1234_5678;
    rst_ni = 1'b0; irq_req_i = '0; trap_i = '0; nmi_i = 1'b0;
    sw_valid_i = 1'b0; sw_vec_i = '0; ack_i = 1'b0;
    m_pend = '0; m_en = '0; m_glob = 1'b0; m_cpu = '0;
    for (int i = 0; i < N; i++) begin m_lvl[i] = '0; m_grp[i] = '0; end
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    cyc();
    // R10 reset state
    chk("R10 outputs", 32'({req_o, kind_o, save_ctx_o}), 32'd0);
    chk("R10 pend", 32'(pend_o), 32'd0);

    // R6 ack while idle has no effect
    ack_i = 1'b1; cyc(); ack_i = 1'b0;
    chk("R6 idle ack save", 32'(save_ctx_o), 32'd0);
    chk("R6 idle ack pend", 32'(pend_o), 32'd0);

    // R2 level equal to cpu priority, level 0
    m_glob = 1'b1; m_en = '1; m_cpu = 4'd4;
    m_lvl[6] = 4'd4; m_grp[6] = 3'd5; m_lvl[7] = 4'd0;
    pulse_irq(16'h00C0);
    chk("R1 pend", 32'(pend_o), 32'(m_pend));
    out_chk("R2 equal level blocked", 2'd0, 0, 4'd0, 3'd0);
    m_cpu = 4'd3; cyc();
    out_chk("R2 above cpu", 2'd1, 6, 4'd4, 3'd5);
    m_glob = 1'b0; cyc();
    out_chk("R2 global enable off", 2'd0, 0, 4'd0, 3'd0);
    m_glob = 1'b1; m_cpu = 4'd0; cyc();
    out_chk("R2 level 0 never", 2'd1, 6, 4'd4, 3'd5);
    ack_irq("R2 drain");
    chk("R2 level 0 still pending", 32'(pend_o), 32'h0080);
    m_lvl[7] = 4'd1; cyc();
    chk_irq("R5 level change");
    ack_irq("R2 drain2");

    // R4 tie and R3 group order
    m_lvl[5] = 4'd7; m_grp[5] = 3'd3;
    m_lvl[9] = 4'd7; m_grp[9] = 3'd3;
    m_lvl[2] = 4'd7; m_grp[2] = 3'd1;
    pulse_irq(16'h0224);
    out_chk("R4 tie lower index", 2'd1, 5, 4'd7, 3'd3);
    // R5 no change before the edge
    m_cpu = 4'd15; #1;
    chk("R5 registered", 32'(req_o), 32'd1);
    cyc();
    chk("R5 after edge", 32'(req_o), 32'd0);
    m_cpu = 4'd0; cyc();
    ack_irq("R4 second");
    chk("R4 second vec", 32'(vec_o), 32'd9);
    ack_irq("R3 group lower");
    chk("R3 last vec", 32'(vec_o), 32'd2);
    ack_irq("R3 empty");
    cyc();
    chk("R9 save low", 32'(save_ctx_o), 32'd0);

    // random sweep
    for (int t = 0; t < 200; t++) begin
      logic [31:0] r;
      for (int i = 0; i < N; i++) begin
        r = rnd();
        m_en[i] = (r[3:0] != 4'd0);
        m_lvl[i] = r[11:8];
        m_grp[i] = r[18:16];
      end
      r = rnd();
      m_cpu = r[3:0] & r[7:4];
      m_glob = (t % 8) != 7;
      pulse_irq(r[31:16]);
      chk("R1 sweep pend", 32'(pend_o), 32'(m_pend));
      chk_irq("R3 sweep winner");
      for (int k = 0; k < N && m_win() >= 0; k++) ack_irq("R6 sweep drain");
      m_en = '1; m_glob = 1'b1; m_cpu = 4'd0;
      for (int i = 0; i < N; i++) if (m_lvl[i] == 4'd0) m_lvl[i] = 4'd1;
      cyc();
      chk_irq("R5 sweep reconfig");
      for (int k = 0; k < N && m_win() >= 0; k++) ack_irq("R6 sweep clean");
      chk("R6 sweep empty", 32'(pend_o), 32'd0);
    end

    // R7 hardware traps
    m_en = '1; m_glob = 1'b1; m_cpu = 4'd0; m_lvl[3] = 4'd5; m_grp[3] = 3'd2;
    pulse_irq(16'h0008);
    out_chk("R3 irq before trap", 2'd1, 3, 4'd5, 3'd2);
    m_glob = 1'b0; m_cpu = 4'd15;
    trap_i = 2'b10; nmi_i = 1'b1; cyc(); trap_i = '0; nmi_i = 1'b0;
    out_chk("R7 nmi first", 2'd3, 0, 4'd15, 3'd7);
    ack_raw();
    out_chk("R7 trap 1", 2'd3, 2, 4'd15, 3'd7);
    chk("R9 trap save", 32'(save_ctx_o), 32'd1);
    ack_raw();
    out_chk("R7 traps drained", 2'd0, 0, 4'd0, 3'd0);
    m_glob = 1'b1; m_cpu = 4'd0; cyc();
    out_chk("R7 irq returns", 2'd1, 3, 4'd5, 3'd2);

    // R8 software trap
    trap_i = 2'b01; sw_valid_i = 1'b1; sw_vec_i = 7'd45; cyc();
    trap_i = '0; sw_valid_i = 1'b0;
    out_chk("R8 hw over sw", 2'd3, 1, 4'd15, 3'd7);
    sw_valid_i = 1'b1; sw_vec_i = 7'd9; cyc(); sw_valid_i = 1'b0;
    out_chk("R8 still hw", 2'd3, 1, 4'd15, 3'd7);
    ack_raw();
    out_chk("R8 sw trap", 2'd2, 45, 4'd15, 3'd7);
    m_glob = 1'b0; cyc();
    out_chk("R8 sw not gated", 2'd2, 45, 4'd15, 3'd7);
    m_glob = 1'b1;
    ack_raw();
    out_chk("R8 dropped second", 2'd1, 3, 4'd5, 3'd2);
    m_pend[3] = 1'b1;
    ack_irq("R6 final");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule